// File: doc/BRIEF.md
# Serial Byte Transmitter with Line Framing Control

This block turns bytes into asynchronous serial frames. A byte arrives through a valid/ready write port and lands in a one-entry holding register. When the shift stage is idle, the byte moves across on the next clock. The shift stage then drives the serial line with a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop period. The line idles high.

Framing comes from a 7-bit line control word. Bits [1:0] give the word length, bit 2 gives the stop length, bit 3 enables parity, bit 4 selects even parity, bit 5 selects fixed ("stick") parity and bit 6 forces a break. The divisor select bit of the full 8-bit control byte belongs to the baud generator, so this block does not receive it.

The block does not divide the clock itself. Its timing comes from a one-clock enable pulse that runs at 16 times the bit rate. Every bit lasts that many pulses, and clocks without a pulse change nothing in the frame.

Back-pressure works as follows. `wr_ready` is high exactly when the holding register is empty. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The writer keeps `wr_data` steady while it waits. `wr_ready` also serves as the holding-empty flag.

Top module: `uart_line_tx`

## Requirements
- R1: During reset and after it ends, with nothing written: `txd` is 1, `wr_ready` is 1 and `shift_empty` is 1.
- R2: A write is taken on an edge where `wr_valid` and `wr_ready` are both high. From the next cycle `wr_ready` stays 0 until that byte moves into the shift stage. While `wr_ready` is 0, `wr_valid` has no effect.
- R3: The byte moves to the shift stage on the first clock edge where the holding register is full and the shift stage is idle. On that edge `wr_ready` rises and `shift_empty` falls.
- R4: The frame begins with a start bit at 0. It is followed by N data bits, least significant first, where `line_ctl[1:0]` values 00, 01, 10 and 11 give N = 5, 6, 7 and 8. Data bits above N are not sent.
- R5: Each start, data and parity bit lasts exactly OVS pulses of `baud_tick`. Clocks with `baud_tick` low do not advance the frame.
- R6: The stop period is at level 1. With `line_ctl[2]` = 0 it lasts OVS pulses. With `line_ctl[2]` = 1 it lasts OVS*3/2 pulses when N = 5, and 2*OVS pulses otherwise.
- R7: With `line_ctl[3]` = 1 and `line_ctl[5]` = 0, a parity bit follows the data. When `line_ctl[4]` = 1 the total count of ones in the data and parity bits is even; when `line_ctl[4]` = 0 it is odd. With `line_ctl[3]` = 0 no parity bit is sent.
- R8: With `line_ctl[3]` = 1 and `line_ctl[5]` = 1, the parity bit is the inverse of `line_ctl[4]`, whatever the data.
- R9: While `line_ctl[6]` = 1, `txd` is 0 in the same cycle. Frame timing continues underneath, and the line returns to the frame's level when the bit clears.
- R10: Word length, stop length and parity settings are captured when the byte moves into the shift stage. Changes to `line_ctl` bits 0 to 5 during a frame apply only to later frames.
- R11: `shift_empty` rises on the clock after the last stop pulse. If the holding register is full at that point, the next frame starts one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-clock enable at OVS times the bit rate |
| line_ctl | input | 7 | Framing control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding register empty; write accepted when high with wr_valid |
| txd | output | 1 | Serial line output |
| shift_empty | output | 1 | Shift stage idle, with no frame in progress |

## Verification
The bench builds the block with the default OVS of 16, so stop periods of 16, 24 and 32 pulses are all reached, including the half-bit case. It drives `baud_tick` in three patterns: on every clock, every third clock, and a pseudo-random pattern. These exercise the rule that clocks without a pulse change nothing. A behavioural model builds every frame as a queue of levels and durations and compares all outputs on every clock. The tests cover back-to-back writes while the holding register is full, control changes in the middle of a frame, and a break raised both during a frame and at idle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] wlen;
  } line_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic [3:0] nbits;
    logic       par_en;
    logic       par_bit;
  } frame_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       take,
  output logic       full,
  output logic [7:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic [7:0]    data,
  input  logic [1:0]    wlen,
  input  logic          stop2,
  input  logic          par_en,
  input  logic          even,
  input  logic          stick,
  output frame_t        frame,
  output logic [CW-1:0] stop_len
);
  logic [3:0] nbits;
  logic [7:0] masked;
  logic       ones_odd;

  assign nbits = 4'd5 + {2'b00, wlen};

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      masked[i] = data[i] & (4'(i) < nbits);
    end
  end

  assign ones_odd = ^masked;

  always_comb begin
    frame.data   = masked;
    frame.nbits  = nbits;
    frame.par_en = par_en;
    if (stick) begin
      frame.par_bit = !even;
    end else if (even) begin
      frame.par_bit = ones_odd;
    end else begin
      frame.par_bit = !ones_odd;
    end
  end

  always_comb begin
    if (!stop2) begin
      stop_len = CW'(OVS);
    end else if (wlen == 2'b00) begin
      stop_len = CW'(OVS + OVS / 2);
    end else begin
      stop_len = CW'(2 * OVS);
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  frame_t        frame,
  input  logic [CW-1:0] stop_len,
  output logic          idle,
  output logic          line
);
  tx_state_e     state;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] cur_len;
  logic [CW-1:0] stop_q;
  logic [7:0]    sreg;
  logic [3:0]    left;
  logic          pen_q;
  logic          par_q;
  logic          bit_done;

  assign cur_len  = (state == ST_STOP) ? stop_q : CW'(OVS);
  assign bit_done = tick && (tcnt == cur_len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tcnt   <= '0;
      stop_q <= CW'(OVS);
      sreg   <= '0;
      left   <= '0;
      pen_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (load && state == ST_IDLE) begin
      state  <= ST_START;
      tcnt   <= '0;
      stop_q <= stop_len;
      sreg   <= frame.data;
      left   <= frame.nbits;
      pen_q  <= frame.par_en;
      par_q  <= frame.par_bit;
    end else if (state != ST_IDLE && tick) begin
      if (bit_done) begin
        tcnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            sreg <= {1'b0, sreg[7:1]};
            left <= left - 4'd1;
            if (left == 4'd1) begin
              state <= pen_q ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR:  state <= ST_STOP;
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [6:0] line_ctl,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       txd,
  output logic       shift_empty
);
  localparam int CW = $clog2(2 * OVS + 1);

  line_ctl_t     cfg;
  logic          hold_full;
  logic [7:0]    hold_data;
  logic          take;
  logic          line_raw;
  frame_t        frame;
  logic [CW-1:0] stop_len;

  assign cfg  = line_ctl_t'(line_ctl);
  assign take = hold_full && shift_empty;

  uart_tx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_valid),
    .in_data  (wr_data),
    .in_ready (wr_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tx_framer #(.OVS(OVS), .CW(CW)) u_framer (
    .data     (hold_data),
    .wlen     (cfg.wlen),
    .stop2    (cfg.stop2),
    .par_en   (cfg.par_en),
    .even     (cfg.even),
    .stick    (cfg.stick),
    .frame    (frame),
    .stop_len (stop_len)
  );

  uart_tx_shifter #(.OVS(OVS), .CW(CW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .load     (take),
    .frame    (frame),
    .stop_len (stop_len),
    .idle     (shift_empty),
    .line     (line_raw)
  );

  assign txd = cfg.brk ? 1'b0 : line_raw;
endmodule

// File: rtl/uart_line_tx_chk.sv
module uart_line_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [6:0] line_ctl,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       txd,
  input logic       shift_empty,
  input logic       line_raw
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_empty && !line_ctl[6]) |-> txd);

  p_take_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  p_move_to_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> $fell(shift_empty));

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !shift_empty) |=> ($stable(line_raw) && !shift_empty));

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctl[6] |-> !txd);

  p_empty_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> ($past(baud_tick) && $past(line_raw)));
endmodule

bind uart_line_tx uart_line_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .baud_tick   (baud_tick),
  .line_ctl    (line_ctl),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .txd         (txd),
  .shift_empty (shift_empty),
  .line_raw    (line_raw)
);

// File: tb/uart_line_tx_tb.sv
module uart_line_tx_tb;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [6:0] line_ctl = 7'd3;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_ready, txd, shift_empty;

  int    n_checks = 0;
  int    n_fail = 0;
  int    tick_mode = 0;
  int    cycles = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  uart_line_tx #(.OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctl(line_ctl),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .txd(txd), .shift_empty(shift_empty)
  );

  always #10 clk = ~clk;

  // tick pattern driven 4 ns after each rising edge
  always begin
    @(posedge clk);
    #4;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: baud_tick = 1'b1;
      1: baud_tick = (cycles % 3 == 0);
      default: baud_tick = lfsr[0] ^ lfsr[5];
    endcase
  end

  // behavioural reference: queue of (level, duration in ticks)
  int         q_lvl[$];
  int         q_dur[$];
  int         m_cnt = 0;
  bit         m_full = 0;
  logic [7:0] m_data = 0;

  task automatic build_frame(input logic [7:0] d, input logic [6:0] c);
    int n;
    int ones;
    int p;
    n = 5 + c[1:0];
    ones = 0;
    q_lvl.push_back(0); q_dur.push_back(OVS);
    for (int i = 0; i < n; i++) begin
      q_lvl.push_back(d[i]); q_dur.push_back(OVS);
      ones += d[i];
    end
    if (c[3]) begin
      if (c[5]) p = c[4] ? 0 : 1;
      else if (c[4]) p = ones % 2;
      else p = 1 - (ones % 2);
      q_lvl.push_back(p); q_dur.push_back(OVS);
    end
    q_lvl.push_back(1);
    if (!c[2]) q_dur.push_back(OVS);
    else if (n == 5) q_dur.push_back(OVS * 3 / 2);
    else q_dur.push_back(2 * OVS);
  endtask

  always @(posedge clk) begin
    bit was_full;
    bit was_idle;
    cycles++;
    if (!rst_n) begin
      m_full = 0;
      q_lvl.delete();
      q_dur.delete();
      m_cnt = 0;
    end else begin
      was_full = m_full;
      was_idle = (q_lvl.size() == 0);
      if (!was_idle && baud_tick) begin
        m_cnt++;
        if (m_cnt == q_dur[0]) begin
          void'(q_lvl.pop_front());
          void'(q_dur.pop_front());
          m_cnt = 0;
        end
      end
      if (was_idle && was_full) begin
        build_frame(m_data, line_ctl);
        m_full = 0;
        m_cnt = 0;
      end
      if (!was_full && wr_valid) begin
        m_full = 1;
        m_data = wr_data;
      end
    end
  end

  task automatic check(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic e_txd;
    if (rst_n) begin
      e_txd = line_ctl[6] ? 1'b0 : ((q_lvl.size() == 0) ? 1'b1 : 1'(q_lvl[0]));
      check("txd", txd, e_txd);
      check("wr_ready", wr_ready, !m_full);
      check("shift_empty", shift_empty, q_lvl.size() == 0);
    end
  end

  task automatic send(input logic [7:0] d);
    bit done;
    done = 0;
    wr_data = d;
    wr_valid = 1'b1;
    while (!done) begin
      @(negedge clk);
      if (wr_ready) begin
        @(posedge clk);
        #4;
        wr_valid = 1'b0;
        done = 1;
      end
    end
  endtask

  task automatic wait_idle();
    bit done;
    done = 0;
    while (!done) begin
      @(negedge clk);
      if (shift_empty && wr_ready) done = 1;
    end
    repeat (3) @(posedge clk);
    #4;
  endtask

  task automatic set_ctl(input logic [6:0] c);
    @(posedge clk);
    #4;
    line_ctl = c;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("txd in reset", txd, 1'b1);
    check("wr_ready in reset", wr_ready, 1'b1);
    check("shift_empty in reset", shift_empty, 1'b1);
    @(posedge clk); #4; rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R4: every word length, R3: transfer into shift stage
    cur_req = "R4";
    for (int w = 0; w < 4; w++) begin
      set_ctl(7'(w));
      send(8'hB5);
      wait_idle();
    end

    // R7: even and odd parity on 8 and 7 bit words
    cur_req = "R7";
    set_ctl(7'b0011011); send(8'h37); wait_idle();
    set_ctl(7'b0001011); send(8'h37); wait_idle();
    set_ctl(7'b0011010); send(8'hF1); wait_idle();
    set_ctl(7'b0001010); send(8'h00); wait_idle();
    set_ctl(7'b0000011); send(8'h81); wait_idle();

    // R8: stick parity both levels
    cur_req = "R8";
    set_ctl(7'b0111011); send(8'h01); wait_idle();
    set_ctl(7'b0101011); send(8'h03); wait_idle();

    // R6 and R5: long stop periods under a sparse tick
    cur_req = "R6";
    tick_mode = 1;
    set_ctl(7'b0000100); send(8'h15); wait_idle();
    set_ctl(7'b0000111); send(8'hA6); wait_idle();
    set_ctl(7'b0001101); send(8'h2C); wait_idle();

    // R5: irregular tick pattern
    cur_req = "R5";
    tick_mode = 2;
    set_ctl(7'b0011111); send(8'h5A); wait_idle();

    // R2, R3, R11: back-to-back writes with back-pressure
    cur_req = "R2";
    tick_mode = 0;
    set_ctl(7'b0000011);
    send(8'h11);
    send(8'h22);
    cur_req = "R11";
    send(8'h33);
    wait_idle();

    // R10: control changes mid-frame apply to later frames only
    cur_req = "R10";
    set_ctl(7'b0011111);
    send(8'hC3);
    repeat (40) @(posedge clk);
    #4;
    line_ctl = 7'b0100000;
    send(8'h1E);
    wait_idle();

    // R9: break during a frame and at idle
    cur_req = "R9";
    set_ctl(7'b0000011);
    send(8'hFF);
    repeat (30) @(posedge clk);
    #4;
    line_ctl = 7'b1000011;
    repeat (50) @(posedge clk);
    #4;
    line_ctl = 7'b0000011;
    wait_idle();
    set_ctl(7'b1000011);
    repeat (10) @(posedge clk);
    set_ctl(7'b0000011);
    repeat (10) @(posedge clk);

    finish_run();
  end
endmodule